// File: doc/BRIEF.md
# Set-Associative Read Cache with Age-Ordered Replacement

This block sits between a CPU load/store port and a slower block-oriented memory. It splits each byte address into tag, set index and block offset fields. Every way of the selected set is compared at once, and the block reports whether the access hit. A read hit returns its word in the next cycle. A read miss holds the CPU off, fetches the whole block from memory and installs it in the way chosen by an age order kept per set. It then returns the requested word. With `WAYS = 1` the same RTL is a direct-mapped cache.

Stores are write-through and never allocate. A store that hits also updates the cached word, and every store is sent to memory. A `flush` input drops every valid bit and returns all age orders to their reset state.

The CPU request port is valid/ready. `cpu_req_ready` is high only while the cache is idle, and a request counts when valid and ready are both high at a rising edge. The response port has no back-pressure: `cpu_rsp_valid` is a one-cycle pulse that the CPU must take. The memory request port is valid/ready, and the cache keeps valid and every request field steady until ready is seen. The memory response is a one-cycle `mem_rsp_valid` pulse carrying the whole block, and the cache only looks at it while it is waiting for a fill. `LINES / WAYS` must be at least 2, and `BLOCK_BYTES` must be a power of two no smaller than one word.

Top module: `lru_set_cache`

## Requirements
- R1: The low log2(BLOCK_BYTES) address bits are the block offset. The next log2(LINES/WAYS) bits select the set, so the set is the block address modulo the number of sets. The remaining upper bits are the tag. A fill request carries the block-aligned address, with the offset bits zero.
- R2: A lookup hits only when some way of the selected set has its valid bit set and a stored tag equal to the address tag. All ways are compared in the same cycle, and at most one way matches.
- R3: An accepted read that hits gives `cpu_rsp_valid` = 1 and `cpu_rsp_hit` = 1 exactly one cycle after acceptance. `cpu_rsp_rdata` is the block word chosen by the address bits between the byte offset (2 bits) and the set index.
- R4: An accepted read that misses drops `cpu_req_ready` in the next cycle and raises a memory read (`mem_req_write` = 0), which is held steady until `mem_req_ready`. One cycle after `mem_rsp_valid`, the cache responds with `cpu_rsp_hit` = 0 and the requested word of the returned block.
- R5: A fill goes to the lowest-numbered invalid way of the set. If every way is valid, it goes to the way unused for longest. A direct-mapped cache has only one candidate.
- R6: Every read hit, store hit and fill makes the way it touched the most recent one in its set. Ways that were more recent than it each age by one step.
- R7: A 2-way cache of 16 one-word blocks starts empty and sees the word addresses 1,4,8,5,20,17,19,56,9,11,4,43,5,6,9,17. It hits only on references 11, 13, 15 and 16.
- R8: For the same sequence, a direct-mapped cache of 16 one-word blocks hits only on references 13, 15 and 16. A direct-mapped cache of 4 four-word blocks hits only on references 4, 7, 10, 13, 14 and 16.
- R9: A store raises a memory write (`mem_req_write` = 1) with the word-aligned address and the store data. When memory takes it, the cache responds one cycle later, with `cpu_rsp_hit` giving the lookup result and `cpu_rsp_rdata` echoing the store data. A store hit updates the cached word. A store miss does not install a block.
- R10: A cycle with `flush` high clears all valid bits and age orders, so the next lookup misses.
- R11: After reset `cpu_req_ready` = 1, `cpu_rsp_valid` = 0, `mem_req_valid` = 0, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all blocks and reset the age orders |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Cache can take a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W (16) | Byte address |
| cpu_req_wdata | input | WORD_W (32) | Store data |
| cpu_rsp_valid | output | 1 | Response pulse |
| cpu_rsp_hit | output | 1 | The request hit in the cache |
| cpu_rsp_rdata | output | WORD_W (32) | Load data, or the echoed store data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = word write, 0 = block read |
| mem_req_addr | output | ADDR_W (16) | Block-aligned (read) or word-aligned (write) byte address |
| mem_req_wdata | output | WORD_W (32) | Write data |
| mem_rsp_valid | input | 1 | Block read data pulse |
| mem_rsp_block | input | BLOCK_BYTES*8 (32) | Whole block, word 0 in the low bits |

## Verification
The same sixteen-reference address stream is run through three configurations: 2-way with one-word blocks, direct-mapped with one-word blocks, and direct-mapped with four-word blocks. The three hit patterns differ, so they separate set selection, associative matching and spatial reuse within a block. A separate stream touches one set with the pattern A, B, A, C, A, B. It tells age-ordered eviction apart from first-in-first-out eviction, which would evict A instead of B. Store hits and misses, each followed by a load, show that the cached word is updated and that a store miss installs nothing. A flush followed by a load shows that the flush clears the cache.

// File: rtl/lru_cache_pkg.sv
package lru_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_WR_REQ
  } cache_state_e;

  function automatic int sel_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cache_way_cmp.sv
module cache_way_cmp #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 11,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]             set_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  set_tags,
  input  logic [TAG_W-1:0]            look_tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = set_valid[w] && (set_tags[w] == look_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/cache_lru_ages.sv
module cache_lru_ages #(
  parameter int WAYS  = 2,
  parameter int SETS  = 8,
  parameter int WAY_W = 1,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] pick_set,
  input  logic [WAYS-1:0]  pick_valid,
  output logic [WAY_W-1:0] victim
);
  if (WAYS == 1) begin : g_direct
    assign victim = '0;
  end else begin : g_assoc
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic             found;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end else if (flush) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end else if (touch_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way)
            age_q[touch_set][w] <= '0;
          else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
            age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
        end
      end
    end

    always_comb begin
      found  = 1'b0;
      victim = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (!found && !pick_valid[w]) begin
          victim = WAY_W'(w);
          found  = 1'b1;
        end
      end
      if (!found) begin
        for (int w = 0; w < WAYS; w++)
          if (age_q[pick_set][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
      end
    end

    // R6
    touched_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_en && !flush) |=> (age_q[$past(touch_set)][$past(touch_way)] == '0));
  end
endmodule

// File: rtl/lru_set_cache.sv
module lru_set_cache
  import lru_cache_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WORD_W      = 32,
  parameter int LINES       = 16,
  parameter int WAYS        = 2,
  parameter int BLOCK_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     cpu_req_valid,
  output logic                     cpu_req_ready,
  input  logic                     cpu_req_write,
  input  logic [ADDR_W-1:0]        cpu_req_addr,
  input  logic [WORD_W-1:0]        cpu_req_wdata,
  output logic                     cpu_rsp_valid,
  output logic                     cpu_rsp_hit,
  output logic [WORD_W-1:0]        cpu_rsp_rdata,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic                     mem_req_write,
  output logic [ADDR_W-1:0]        mem_req_addr,
  output logic [WORD_W-1:0]        mem_req_wdata,
  input  logic                     mem_rsp_valid,
  input  logic [BLOCK_BYTES*8-1:0] mem_rsp_block
);
  localparam int BLK_W  = BLOCK_BYTES * 8;
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int WORDS  = BLK_W / WORD_W;
  localparam int WSEL_W = sel_bits(WORDS);
  localparam int SETS   = LINES / WAYS;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W  = sel_bits(WAYS);

  cache_state_e state_q;
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [BLK_W-1:0] blk_q   [SETS][WAYS];

  logic [ADDR_W-1:0] pend_addr_q;
  logic [WORD_W-1:0] pend_wdata_q;
  logic              wr_hit_q;

  logic [ADDR_W-1:0]            cur_addr;
  logic [IDX_W-1:0]             cur_idx;
  logic [TAG_W-1:0]             cur_tag;
  logic [WSEL_W-1:0]            word_idx;
  logic [WAYS-1:0][TAG_W-1:0]   set_tags;
  logic [WAYS-1:0]              set_valid;
  logic [WAYS-1:0]              hit_vec;
  logic                         look_hit;
  logic [WAY_W-1:0]             hit_way;
  logic [WAY_W-1:0]             victim;
  logic                         accept;
  logic                         fill_done;
  logic                         touch_en;
  logic [WAY_W-1:0]             touch_way;
  logic [BLK_W-1:0]             hit_blk;

  assign cur_addr  = (state_q == ST_IDLE) ? cpu_req_addr : pend_addr_q;
  assign cur_idx   = cur_addr[OFF_W +: IDX_W];
  assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
  assign word_idx  = WSEL_W'(cur_addr[OFF_W-1:0] >> BOFF_W);
  assign set_valid = valid_q[cur_idx];

  always_comb begin
    for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[cur_idx][w];
  end

  cache_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) cmp_i (
    .set_valid (set_valid),
    .set_tags  (set_tags),
    .look_tag  (cur_tag),
    .hit_vec   (hit_vec),
    .hit       (look_hit),
    .hit_way   (hit_way)
  );

  assign accept    = cpu_req_valid && cpu_req_ready;
  assign fill_done = (state_q == ST_FILL_WAIT) && mem_rsp_valid;
  assign touch_en  = (accept && look_hit) || fill_done;
  assign touch_way = (state_q == ST_IDLE) ? hit_way : victim;
  assign hit_blk   = blk_q[cur_idx][hit_way];

  cache_lru_ages #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .IDX_W(IDX_W)) ages_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .touch_en   (touch_en),
    .touch_set  (cur_idx),
    .touch_way  (touch_way),
    .pick_set   (cur_idx),
    .pick_valid (set_valid),
    .victim     (victim)
  );

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_FILL_REQ) || (state_q == ST_WR_REQ);
  assign mem_req_write = (state_q == ST_WR_REQ);
  assign mem_req_wdata = pend_wdata_q;
  assign mem_req_addr  = (state_q == ST_WR_REQ)
                       ? {pend_addr_q[ADDR_W-1:BOFF_W], BOFF_W'(0)}
                       : {pend_addr_q[ADDR_W-1:OFF_W], OFF_W'(0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_hit   <= 1'b0;
      cpu_rsp_rdata <= '0;
      pend_addr_q   <= '0;
      pend_wdata_q  <= '0;
      wr_hit_q      <= 1'b0;
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          pend_addr_q  <= cpu_req_addr;
          pend_wdata_q <= cpu_req_wdata;
          if (cpu_req_write) begin
            wr_hit_q <= look_hit;
            state_q  <= ST_WR_REQ;
          end else if (look_hit) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_hit   <= 1'b1;
            cpu_rsp_rdata <= hit_blk[word_idx*WORD_W +: WORD_W];
          end else begin
            state_q <= ST_FILL_REQ;
          end
        end
        ST_FILL_REQ: if (mem_req_ready) state_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: if (mem_rsp_valid) begin
          cpu_rsp_valid            <= 1'b1;
          cpu_rsp_hit              <= 1'b0;
          cpu_rsp_rdata            <= mem_rsp_block[word_idx*WORD_W +: WORD_W];
          valid_q[cur_idx][victim] <= 1'b1;
          state_q                  <= ST_IDLE;
        end
        ST_WR_REQ: if (mem_req_ready) begin
          cpu_rsp_valid <= 1'b1;
          cpu_rsp_hit   <= wr_hit_q;
          cpu_rsp_rdata <= pend_wdata_q;
          state_q       <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (flush) begin
        for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) begin
      tag_q[cur_idx][victim] <= cur_tag;
      blk_q[cur_idx][victim] <= mem_rsp_block;
    end else if (accept && cpu_req_write && look_hit) begin
      blk_q[cur_idx][hit_way][word_idx*WORD_W +: WORD_W] <= cpu_req_wdata;
    end
  end

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R3
  hit_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_req_write && look_hit) |=> (cpu_rsp_valid && cpu_rsp_hit));
  // R4
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_req_write && !look_hit) |=>
      (!cpu_req_ready && mem_req_valid && !mem_req_write));
  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
  // R5
  victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && !(&set_valid)) |-> !set_valid[victim]);
  // R9
  store_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_req_write) |=> (mem_req_valid && mem_req_write));
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !look_hit);
endmodule

// File: tb/lru_set_cache_tb_top.sv
module blk_mem_stub #(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 4,
  parameter int LAT         = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  output logic [BLOCK_BYTES*8-1:0] rsp_block,
  output logic [ADDR_W-1:0]        last_rd_addr,
  output logic [ADDR_W-1:0]        last_wr_addr,
  output logic [31:0]              last_wr_data
);
  logic busy;
  int   cnt;
  logic [ADDR_W-1:0] base;

  assign req_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= 0; base <= '0; rsp_valid <= 1'b0; rsp_block <= '0;
      last_rd_addr <= '0; last_wr_addr <= '0; last_wr_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy && req_valid && !req_write) begin
        busy <= 1'b1; cnt <= LAT; base <= req_addr; last_rd_addr <= req_addr;
      end else if (busy) begin
        if (cnt == 0) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          for (int i = 0; i < BLOCK_BYTES / 4; i++)
            rsp_block[i*32 +: 32] <= 32'h3C00_0000 + (32'(base >> 2) + 32'(i)) * 32'h0001_0003;
        end else cnt <= cnt - 1;
      end
      if (!busy && req_valid && req_write) begin
        last_wr_addr <= req_addr; last_wr_data <= req_wdata;
      end
    end
  end
endmodule

module lru_set_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        rv [3], rw [3], rdy [3], rsv [3], rsh [3], fl [3];
  logic [15:0] ra [3];
  logic [31:0] rwd [3], rsd [3];
  logic        mv [3], mrdy [3], mw [3], mrv [3];
  logic [15:0] ma [3], lrd [3], lwa [3];
  logic [31:0] mwd [3], lwd [3];
  logic [31:0]  mb0, mb1;
  logic [127:0] mb2;

  int errors = 0, checks = 0, ncyc = 0;
  logic [65:0] exp_q [$];
  string       lbl_q [$];

  function automatic logic [31:0] mem_word(input int w);
    return 32'h3C00_0000 + 32'(w) * 32'h0001_0003;
  endfunction

  lru_set_cache #(.WAYS(2), .LINES(16), .BLOCK_BYTES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(fl[0]), .cpu_req_valid(rv[0]), .cpu_req_ready(rdy[0]),
    .cpu_req_write(rw[0]), .cpu_req_addr(ra[0]), .cpu_req_wdata(rwd[0]),
    .cpu_rsp_valid(rsv[0]), .cpu_rsp_hit(rsh[0]), .cpu_rsp_rdata(rsd[0]),
    .mem_req_valid(mv[0]), .mem_req_ready(mrdy[0]), .mem_req_write(mw[0]),
    .mem_req_addr(ma[0]), .mem_req_wdata(mwd[0]), .mem_rsp_valid(mrv[0]), .mem_rsp_block(mb0));
  blk_mem_stub #(.BLOCK_BYTES(4)) mem0_i (
    .clk(clk), .rst_n(rst_n), .req_valid(mv[0]), .req_ready(mrdy[0]), .req_write(mw[0]),
    .req_addr(ma[0]), .req_wdata(mwd[0]), .rsp_valid(mrv[0]), .rsp_block(mb0),
    .last_rd_addr(lrd[0]), .last_wr_addr(lwa[0]), .last_wr_data(lwd[0]));

  lru_set_cache #(.WAYS(1), .LINES(16), .BLOCK_BYTES(4)) dm16_i (
    .clk(clk), .rst_n(rst_n), .flush(fl[1]), .cpu_req_valid(rv[1]), .cpu_req_ready(rdy[1]),
    .cpu_req_write(rw[1]), .cpu_req_addr(ra[1]), .cpu_req_wdata(rwd[1]),
    .cpu_rsp_valid(rsv[1]), .cpu_rsp_hit(rsh[1]), .cpu_rsp_rdata(rsd[1]),
    .mem_req_valid(mv[1]), .mem_req_ready(mrdy[1]), .mem_req_write(mw[1]),
    .mem_req_addr(ma[1]), .mem_req_wdata(mwd[1]), .mem_rsp_valid(mrv[1]), .mem_rsp_block(mb1));
  blk_mem_stub #(.BLOCK_BYTES(4)) mem1_i (
    .clk(clk), .rst_n(rst_n), .req_valid(mv[1]), .req_ready(mrdy[1]), .req_write(mw[1]),
    .req_addr(ma[1]), .req_wdata(mwd[1]), .rsp_valid(mrv[1]), .rsp_block(mb1),
    .last_rd_addr(lrd[1]), .last_wr_addr(lwa[1]), .last_wr_data(lwd[1]));

  lru_set_cache #(.WAYS(1), .LINES(4), .BLOCK_BYTES(16)) dm4_i (
    .clk(clk), .rst_n(rst_n), .flush(fl[2]), .cpu_req_valid(rv[2]), .cpu_req_ready(rdy[2]),
    .cpu_req_write(rw[2]), .cpu_req_addr(ra[2]), .cpu_req_wdata(rwd[2]),
    .cpu_rsp_valid(rsv[2]), .cpu_rsp_hit(rsh[2]), .cpu_rsp_rdata(rsd[2]),
    .mem_req_valid(mv[2]), .mem_req_ready(mrdy[2]), .mem_req_write(mw[2]),
    .mem_req_addr(ma[2]), .mem_req_wdata(mwd[2]), .mem_rsp_valid(mrv[2]), .mem_rsp_block(mb2));
  blk_mem_stub #(.BLOCK_BYTES(16)) mem2_i (
    .clk(clk), .rst_n(rst_n), .req_valid(mv[2]), .req_ready(mrdy[2]), .req_write(mw[2]),
    .req_addr(ma[2]), .req_wdata(mwd[2]), .rsp_valid(mrv[2]), .rsp_block(mb2),
    .last_rd_addr(lrd[2]), .last_wr_addr(lwa[2]), .last_wr_data(lwd[2]));

  task automatic check(input bit ok, input string lbl, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a response appears
  always @(negedge clk) begin
    logic [65:0] e;
    string l;
    ncyc++;
    for (int k = 0; k < 3; k++) begin
      if (rsv[k]) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected response", 32'(k), 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          l = lbl_q.pop_front();
          check(rsh[k] == e[64], {l, " hit"}, 32'(rsh[k]), 32'(e[64]));
          check(rsd[k] == e[63:32], {l, " data"}, rsd[k], e[63:32]);
          if (e[65]) check(ncyc == int'(e[31:0]) + 1, "R3 hit latency",
                           32'(ncyc - int'(e[31:0])), 32'd1);
        end
      end
    end
  end

  task automatic access(input int k, input bit wr, input int w, input logic [31:0] wd,
                        input bit eh, input logic [31:0] ed, input string lbl);
    @(negedge clk); #1;
    rv[k] = 1'b1; rw[k] = wr; ra[k] = 16'(w << 2); rwd[k] = wd;
    while (!rdy[k]) begin @(negedge clk); #1; end
    exp_q.push_back({(eh && !wr), eh, ed, 32'(ncyc)});
    lbl_q.push_back(lbl);
    @(negedge clk); #1;
    rv[k] = 1'b0;
    if (!wr && !eh) check(rdy[k] == 1'b0, "R4 ready low during miss", 32'(rdy[k]), 32'd0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_seq(input int k, input logic [15:0] mask, input string tag);
    int seq [16] = '{1, 4, 8, 5, 20, 17, 19, 56, 9, 11, 4, 43, 5, 6, 9, 17};
    for (int i = 0; i < 16; i++)
      access(k, 1'b0, seq[i], 32'h0, mask[i], mem_word(seq[i]), $sformatf("%s ref%0d", tag, i + 1));
    drain();
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin
      rv[k] = 0; rw[k] = 0; ra[k] = 0; rwd[k] = 0; fl[k] = 0;
    end
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
          check(rdy[k] == 1'b1, "R11 ready after reset", 32'(rdy[k]), 32'd1);
          check(rsv[k] == 1'b0, "R11 no response after reset", 32'(rsv[k]), 32'd0);
          check(mv[k] == 1'b0, "R11 no memory request after reset", 32'(mv[k]), 32'd0);
        end
        // hit patterns: bit i set = reference i+1 hits
        run_seq(0, 16'hD400, "R7");
        run_seq(1, 16'hD000, "R8 dm16");
        run_seq(2, 16'hB248, "R8 dm4x4");
        // R1: block-aligned fill address, R3 word select within block
        access(2, 1'b0, 27, 32'h0, 1'b0, mem_word(27), "R1 miss word27");
        drain();
        check(lrd[2] == 16'd96, "R1 fill address aligned", 32'(lrd[2]), 32'd96);
        access(2, 1'b0, 25, 32'h0, 1'b1, mem_word(25), "R3 word select word25");
        drain();
        // R9 store hit and store miss
        access(0, 1'b1, 4, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF, "R9 store hit");
        drain();
        check(lwa[0] == 16'd16, "R9 write address", 32'(lwa[0]), 32'd16);
        check(lwd[0] == 32'hDEAD_BEEF, "R9 write data", lwd[0], 32'hDEAD_BEEF);
        access(0, 1'b0, 4, 32'h0, 1'b1, 32'hDEAD_BEEF, "R9 updated word");
        access(0, 1'b1, 100, 32'h1234_5678, 1'b0, 32'h1234_5678, "R9 store miss");
        access(0, 1'b0, 100, 32'h0, 1'b0, mem_word(100), "R9 no allocate");
        drain();
        // R10 flush
        @(negedge clk); #1; fl[0] = 1'b1;
        @(negedge clk); #1; fl[0] = 1'b0;
        access(0, 1'b0, 4, 32'h0, 1'b0, mem_word(4), "R10 miss after flush");
        // R6 / R5 in set 0: A=0, B=8, A, C=16 evicts B, A hits, B misses
        access(0, 1'b0, 0,  32'h0, 1'b0, mem_word(0),  "R5 fill free way A");
        access(0, 1'b0, 8,  32'h0, 1'b0, mem_word(8),  "R5 fill free way B");
        access(0, 1'b0, 0,  32'h0, 1'b1, mem_word(0),  "R6 hit A");
        access(0, 1'b0, 16, 32'h0, 1'b0, mem_word(16), "R6 fill C");
        access(0, 1'b0, 0,  32'h0, 1'b1, mem_word(0),  "R6 A kept");
        access(0, 1'b0, 8,  32'h0, 1'b0, mem_word(8),  "R6 B evicted");
        drain();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R4 watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule